// File: doc/BRIEF.md
# I2C Register-Pointer Target with 16-bit Registers

This block is an I2C target that fronts a small bank of 16-bit registers. A controller selects a register by writing a one-byte pointer. It may follow the pointer with one 16-bit word, sent as two bytes with the high byte first. A read transaction returns the register that the most recent pointer write selected, again high byte first. The pointer never advances on its own and survives from one transaction to the next, so the controller can poll the same register with plain reads.

SCL and SDA come from open-drain pads. Both pass through two-flop synchronizers before any decoding. The block pulls SDA low through `sda_oe_o` and otherwise leaves the line released. A two-bit select input picks one of four target addresses. Completed writes to writable registers appear as a one-cycle strobe with index and data. The register that the pointer currently selects is always visible on `rd_data_o`.

Top module: `i2c_rp_target`

## Requirements
- R1: The target address is 7'h44 plus `addr_sel_i` (44h to 47h). A matching address byte is ACKed. Any other address gets no ACK, and every later byte up to the next start condition is ignored.
- R2: In a write transaction, the first byte after the address byte loads the pointer. A transaction made of only the address byte and the pointer byte, closed by a stop, is complete: it changes the pointer and no register contents.
- R3: The two bytes after the pointer form one word, high byte first. The word is committed as `wr_stb_o`, with `wr_idx_o` equal to the pointer and `wr_data_o` equal to the word. Every byte of a write transaction addressed to this target is ACKed.
- R4: A write that ends after a single data byte commits nothing and leaves the register unchanged.
- R5: A read transaction sends the pointed register high byte first, then the low byte. The pointer is kept across transactions, so repeated reads return the same register without a new pointer write.
- R6: During a read, a NACK from the controller after a data byte makes the target release SDA. A start or stop condition also returns the target to a released SDA.
- R7: Writes to read-only pointers (00h, 7Eh, 7Fh) or to unimplemented pointers are ACKed and then discarded, with no strobe. Reads from unimplemented pointers return 0000h.
- R8: After reset the pointer is 00h and SDA is released. The register values are as follows. 00h reads `result_i`. 01h reads C810h, 02h reads C000h and 03h reads BFFFh. 7Eh reads 5449h and 7Fh reads 3001h. `rd_data_o` always shows the register selected by the pointer.
- R9: `sda_oe_o` changes only while SCL is low.
- R10: `wr_stb_o` is a single-cycle pulse. It is raised only for pointers 01h to 03h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL pad level |
| sda_i | input | 1 | SDA pad level |
| sda_oe_o | output | 1 | High to pull SDA low |
| addr_sel_i | input | 2 | Selects target address 44h + value |
| result_i | input | 16 | Value of read-only register 00h |
| wr_stb_o | output | 1 | One-cycle commit of a written word |
| wr_idx_o | output | 8 | Register index of the commit |
| wr_data_o | output | 16 | Word being committed |
| rd_data_o | output | 16 | Register selected by the pointer |

## Verification
Two events can land in the same stretch of SCL activity. The first is the word commit, which fires on the eighth rising SCL edge of the second data byte. The second is transaction termination, which can arrive as a stop or a repeated start right after a single data byte or right after an ACK. The bench provokes both. It stops after one data byte and expects no strobe and an unchanged register. It issues a repeated start straight after a pointer write and expects the new pointer to be in force for the read that follows. The read side is judged by a controller NACK, after which SDA must be released so that a stop can complete.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;
  localparam int ADDR_W = 7;
  localparam int PTR_W  = 8;
  localparam int REG_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } st_e;

  // pointers 01h..03h hold writable registers
  function automatic logic is_rw(input logic [PTR_W-1:0] p);
    return (p >= PTR_W'(1)) && (p <= PTR_W'(3));
  endfunction
endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s_o = scl_ff[STAGES-1];
  assign sda_s_o = sda_ff[STAGES-1];
  assign rise_o  = scl_s_o & ~scl_q;
  assign fall_o  = ~scl_s_o & scl_q;
  // SDA edges while SCL stays high
  assign start_o = scl_s_o & scl_q & sda_q & ~sda_s_o;
  assign stop_o  = scl_s_o & scl_q & ~sda_q & sda_s_o;
endmodule

// File: rtl/i2c_rp_engine.sv
module i2c_rp_engine
  import i2c_rp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [REG_W-1:0]  rdata_i,
  output logic              sda_oe_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              cm_stb_o,
  output logic [REG_W-1:0]  cm_data_o
);
  st_e               state;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] sh, tx_sh, hi_q;
  logic [1:0]        wr_cnt;
  logic              rw, lo_sel, nack_q, oe_q;
  logic [REG_W-1:0]  tx_word;
  logic [BYTE_W-1:0] nxt_byte, nxt_tx;

  assign nxt_byte = {sh[BYTE_W-2:0], sda_i};
  assign nxt_tx   = lo_sel ? tx_word[BYTE_W-1:0] : tx_word[REG_W-1:BYTE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      tx_sh     <= '0;
      hi_q      <= '0;
      wr_cnt    <= '0;
      rw        <= 1'b0;
      lo_sel    <= 1'b0;
      nack_q    <= 1'b0;
      oe_q      <= 1'b0;
      tx_word   <= '0;
      ptr_o     <= '0;
      cm_stb_o  <= 1'b0;
      cm_data_o <= '0;
    end else begin
      cm_stb_o <= 1'b0;
      if (start_i) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        wr_cnt <= '0;
        oe_q   <= 1'b0;
      end else if (stop_i) begin
        state <= ST_IDLE;
        oe_q  <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (rise_i) begin
              sh  <= nxt_byte;
              cnt <= cnt + 4'd1;
            end else if (fall_i && cnt == 4'd8) begin
              cnt <= '0;
              if (sh[BYTE_W-1:1] == own_addr_i) begin
                rw    <= sh[0];
                oe_q  <= 1'b1;
                state <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (fall_i) begin
              if (rw) begin
                tx_word <= rdata_i;
                oe_q    <= ~rdata_i[REG_W-1];
                tx_sh   <= {rdata_i[REG_W-2:BYTE_W], 1'b0};
                lo_sel  <= 1'b1;
                state   <= ST_RD;
              end else begin
                oe_q  <= 1'b0;
                state <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (rise_i) begin
              sh  <= nxt_byte;
              cnt <= cnt + 4'd1;
              if (cnt == 4'd7) begin
                case (wr_cnt)
                  2'd0: ptr_o <= nxt_byte;
                  2'd1: hi_q  <= nxt_byte;
                  2'd2: begin
                    cm_stb_o  <= 1'b1;
                    cm_data_o <= {hi_q, nxt_byte};
                  end
                  default: ;
                endcase
                if (wr_cnt != 2'd3) wr_cnt <= wr_cnt + 2'd1;
              end
            end else if (fall_i && cnt == 4'd8) begin
              cnt   <= '0;
              oe_q  <= 1'b1;
              state <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: begin
            if (fall_i) begin
              oe_q  <= 1'b0;
              state <= ST_WR;
            end
          end
          ST_RD: begin
            if (rise_i) begin
              cnt <= cnt + 4'd1;
            end else if (fall_i) begin
              if (cnt == 4'd8) begin
                cnt   <= '0;
                oe_q  <= 1'b0;
                state <= ST_RD_ACK;
              end else begin
                oe_q  <= ~tx_sh[BYTE_W-1];
                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RD_ACK: begin
            if (rise_i) begin
              nack_q <= sda_i;
            end else if (fall_i) begin
              if (nack_q) begin
                state <= ST_IDLE;
              end else begin
                oe_q   <= ~nxt_tx[BYTE_W-1];
                tx_sh  <= {nxt_tx[BYTE_W-2:0], 1'b0};
                lo_sel <= ~lo_sel;
                state  <= ST_RD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/i2c_rp_regs.sv
module i2c_rp_regs
  import i2c_rp_pkg::*;
#(
  parameter logic [REG_W-1:0] CFG_RST = 16'hC810,
  parameter logic [REG_W-1:0] LO_RST  = 16'hC000,
  parameter logic [REG_W-1:0] HI_RST  = 16'hBFFF,
  parameter logic [REG_W-1:0] MFR_ID  = 16'h5449,
  parameter logic [REG_W-1:0] DEV_ID  = 16'h3001
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_idx_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [REG_W-1:0] result_i,
  output logic [REG_W-1:0] rdata_o
);
  localparam int NUM_RW = 3;
  logic [REG_W-1:0] rw_val [NUM_RW];

  for (genvar g = 0; g < NUM_RW; g++) begin : gen_rw
    localparam logic [REG_W-1:0] RV = (g == 0) ? CFG_RST : (g == 1) ? LO_RST : HI_RST;
    logic [REG_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RV;
      else if (wr_en_i && wr_idx_i == PTR_W'(g + 1)) q <= wr_data_i;
    end
    assign rw_val[g] = q;
  end

  always_comb begin
    rdata_o = '0;
    case (ptr_i)
      8'h00: rdata_o = result_i;
      8'h7E: rdata_o = MFR_ID;
      8'h7F: rdata_o = DEV_ID;
      default: begin
        for (int i = 0; i < NUM_RW; i++)
          if (ptr_i == PTR_W'(i + 1)) rdata_o = rw_val[i];
      end
    endcase
  end
endmodule

// File: rtl/i2c_rp_target.sv
module i2c_rp_target
  import i2c_rp_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE_ADDR = 7'h44,
  parameter int                SYNC_STG  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [1:0]       addr_sel_i,
  input  logic [REG_W-1:0] result_i,
  output logic             wr_stb_o,
  output logic [PTR_W-1:0] wr_idx_o,
  output logic [REG_W-1:0] wr_data_o,
  output logic [REG_W-1:0] rd_data_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic cm_stb;
  logic [PTR_W-1:0]  ptr;
  logic [REG_W-1:0]  cm_data;
  logic [ADDR_W-1:0] own_addr;

  assign own_addr = BASE_ADDR + ADDR_W'(addr_sel_i);

  i2c_rp_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .scl_s_o (scl_s),
    .sda_s_o (sda_s),
    .rise_o  (scl_rise),
    .fall_o  (scl_fall),
    .start_o (start_det),
    .stop_o  (stop_det)
  );

  i2c_rp_engine u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .rise_i     (scl_rise),
    .fall_i     (scl_fall),
    .sda_i      (sda_s),
    .own_addr_i (own_addr),
    .rdata_i    (rd_data_o),
    .sda_oe_o   (sda_oe_o),
    .ptr_o      (ptr),
    .cm_stb_o   (cm_stb),
    .cm_data_o  (cm_data)
  );

  assign wr_stb_o  = cm_stb & is_rw(ptr);
  assign wr_idx_o  = ptr;
  assign wr_data_o = cm_data;

  i2c_rp_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_stb_o),
    .wr_idx_i  (wr_idx_o),
    .wr_data_i (wr_data_o),
    .ptr_i     (ptr),
    .result_i  (result_i),
    .rdata_o   (rd_data_o)
  );
endmodule

// File: rtl/i2c_rp_target_chk.sv
module i2c_rp_target_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe_o,
  input logic wr_stb_o
);
  // R9: drive level moves only with SCL low
  a_r9_oe_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);

  // R10: commit strobe lasts one cycle
  a_r10_stb_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o);

  // R6: stop leaves SDA released
  a_r6_stop_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);

  // R6: start leaves SDA released
  a_r6_start_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe_o);
endmodule

bind i2c_rp_target i2c_rp_target_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe_o  (sda_oe_o),
  .wr_stb_o  (wr_stb_o)
);

// File: tb/i2c_rp_target_tb.sv
module i2c_rp_target_tb;
  localparam int Q = 8;
  localparam logic [15:0] RES = 16'h1234;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [1:0] addr_sel = 2'd0;
  logic sda_oe, wr_stb, sda_bus;
  logic [7:0] wr_idx;
  logic [15:0] wr_data, rd_data;

  int n_chk = 0, n_fail = 0, stb_cnt = 0, r9_bad = 0;
  logic [7:0] last_idx = '0;
  logic [15:0] last_data = '0;
  logic oe_prev = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_rp_target u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .result_i(RES), .wr_stb_o(wr_stb), .wr_idx_o(wr_idx),
    .wr_data_o(wr_data), .rd_data_o(rd_data)
  );

  always @(posedge clk) begin
    if (wr_stb) begin
      stb_cnt   <= stb_cnt + 1;
      last_idx  <= wr_idx;
      last_data <= wr_data;
    end
    if (rst_n && sda_oe != oe_prev && scl) r9_bad <= r9_bad + 1;
    oe_prev <= sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; tick(Q); scl = 1'b1; tick(Q); s = sda_bus; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~m_ack, s);
  endtask

  // nd: number of data bytes (0..2); acks packed as {a_addr,a_ptr,a_hi,a_lo}
  task automatic wr_txn(input logic [6:0] a, input logic [7:0] p, input logic [15:0] d,
                        input int nd, output logic [3:0] acks);
    acks = '0;
    i2c_start();
    send_byte({a, 1'b0}, acks[3]);
    send_byte(p, acks[2]);
    if (nd > 0) send_byte(d[15:8], acks[1]);
    if (nd > 1) send_byte(d[7:0], acks[0]);
    i2c_stop();
  endtask

  task automatic rd_txn(input logic [6:0] a, output logic [15:0] w, output logic ack);
    i2c_start();
    send_byte({a, 1'b1}, ack);
    recv_byte(1'b1, w[15:8]);
    recv_byte(1'b0, w[7:0]);
    i2c_stop();
  endtask

  task automatic t_reset();
    chk("R8 reset sda released", 32'(sda_oe), 32'd0);
    chk("R8 reset pointer shows result", 32'(rd_data), 32'(RES));
  endtask

  task automatic t_defaults();
    logic [7:0] ptrs [6] = '{8'h01, 8'h02, 8'h03, 8'h7E, 8'h7F, 8'h00};
    logic [15:0] exps [6] = '{16'hC810, 16'hC000, 16'hBFFF, 16'h5449, 16'h3001, RES};
    logic [3:0] acks;
    logic [15:0] w;
    logic ack;
    for (int i = 0; i < 6; i++) begin
      wr_txn(7'h44, ptrs[i], 16'h0, 0, acks);
      chk("R2 pointer-only write acked", 32'(acks[3:2]), 32'h3);
      chk("R8 rd_data_o after pointer", 32'(rd_data), 32'(exps[i]));
      rd_txn(7'h44, w, ack);
      chk("R5 read of reset value", 32'(w), 32'(exps[i]));
    end
  endtask

  task automatic t_write();
    logic [3:0] acks;
    logic [15:0] w;
    logic ack;
    int c0 = stb_cnt;
    wr_txn(7'h44, 8'h02, 16'hA55A, 2, acks);
    chk("R3 all bytes acked", 32'(acks), 32'hF);
    chk("R10 one strobe", 32'(stb_cnt - c0), 32'd1);
    chk("R3 strobe index", 32'(last_idx), 32'h02);
    chk("R3 strobe data", 32'(last_data), 32'hA55A);
    rd_txn(7'h44, w, ack);
    chk("R5 read back", 32'(w), 32'hA55A);
    rd_txn(7'h44, w, ack);
    chk("R5 repeated read no pointer", 32'(w), 32'hA55A);
    wr_txn(7'h44, 8'h01, 16'h0F3C, 2, acks);
    rd_txn(7'h44, w, ack);
    chk("R3 second register written", 32'(w), 32'h0F3C);
    wr_txn(7'h44, 8'h02, 16'h0, 0, acks);
    chk("R2 pointer-only keeps contents", 32'(rd_data), 32'hA55A);
  endtask

  task automatic t_partial();
    logic [3:0] acks;
    logic [15:0] w;
    logic ack;
    int c0 = stb_cnt;
    wr_txn(7'h44, 8'h03, 16'h1200, 1, acks);
    chk("R4 single byte acked", 32'(acks[3:1]), 32'h7);
    chk("R4 no strobe", 32'(stb_cnt - c0), 32'd0);
    rd_txn(7'h44, w, ack);
    chk("R4 register unchanged", 32'(w), 32'hBFFF);
  endtask

  task automatic t_ro();
    logic [3:0] acks;
    logic [15:0] w;
    logic ack;
    int c0 = stb_cnt;
    wr_txn(7'h44, 8'h00, 16'hFFFF, 2, acks);
    chk("R7 read-only write acked", 32'(acks), 32'hF);
    rd_txn(7'h44, w, ack);
    chk("R7 result unchanged", 32'(w), 32'(RES));
    wr_txn(7'h44, 8'h7F, 16'h0000, 2, acks);
    rd_txn(7'h44, w, ack);
    chk("R7 id unchanged", 32'(w), 32'h3001);
    wr_txn(7'h44, 8'h10, 16'hBEEF, 2, acks);
    chk("R7 unimplemented write acked", 32'(acks), 32'hF);
    rd_txn(7'h44, w, ack);
    chk("R7 unimplemented reads zero", 32'(w), 32'h0000);
    chk("R10 no strobe on discard", 32'(stb_cnt - c0), 32'd0);
  endtask

  task automatic t_addr();
    logic [3:0] acks;
    logic [15:0] w;
    logic ack;
    int c0 = stb_cnt;
    addr_sel = 2'd2;
    tick(4);
    wr_txn(7'h02, 8'h02, 16'h0, 0, acks);
    wr_txn(7'h45, 8'h02, 16'h1111, 2, acks);
    chk("R1 foreign address nacked", 32'(acks), 32'h0);
    chk("R1 foreign bytes ignored ptr", 32'(rd_data), 32'h3001 & 32'h0);
    chk("R1 foreign bytes no strobe", 32'(stb_cnt - c0), 32'd0);
    wr_txn(7'h46, 8'h7E, 16'h0, 0, acks);
    chk("R1 own address acked", 32'(acks[3:2]), 32'h3);
    for (int s = 0; s < 4; s++) begin
      addr_sel = 2'(s);
      tick(4);
      rd_txn(7'(7'h44 + s), w, ack);
      chk("R1 select address ack", 32'(ack), 32'd1);
      chk("R1 select address data", 32'(w), 32'h5449);
    end
    addr_sel = 2'd0;
    tick(4);
  endtask

  task automatic t_nack_rs();
    logic [7:0] b;
    logic [15:0] w;
    logic ack;
    i2c_start();
    send_byte({7'h44, 1'b1}, ack);
    recv_byte(1'b0, b);
    chk("R5 high byte first", 32'(b), 32'h54);
    chk("R6 released after nack", 32'(sda_oe), 32'd0);
    i2c_stop();
    // pointer write closed by repeated start
    i2c_start();
    send_byte({7'h44, 1'b0}, ack);
    send_byte(8'h03, ack);
    i2c_start();
    send_byte({7'h44, 1'b1}, ack);
    chk("R6 repeated start ack", 32'(ack), 32'd1);
    recv_byte(1'b1, w[15:8]);
    recv_byte(1'b0, w[7:0]);
    i2c_stop();
    chk("R6 pointer via repeated start", 32'(w), 32'hBFFF);
    chk("R6 released after stop", 32'(sda_oe), 32'd0);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_defaults();
    t_write();
    t_partial();
    t_ro();
    t_addr();
    t_nack_rs();
    chk("R9 sda drive changed with scl high", 32'(r9_bad), 32'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule